// File: doc/BRIEF.md
# Authenticated Debug Access Gate

This block sits between an external debugger and the system bus and decides, request by request, whether a debug access may pass. A boot sequencer loads a two-bit restriction setting once per boot. The setting is taken from a configuration word when the device is in the normal lifecycle state, and from fuse bits when it is in the secure state. Later loads can only tighten the setting that is already held.

When the setting selects authenticated debugging, every debug access is refused right after boot. A single trusted security master, identified by its bus master ID, then uses a privileged write port. It first opens the debug port and restricts it to a mailbox word plus a small RAM window, which is enough for a password exchange. After it has validated the password, it widens the filter to full access. Any master may issue a privileged write, but writes from any master other than the security master are refused. A disable bit that has been set cannot be cleared until the next boot load, and an enable written while the port is disabled has no effect.

A refused request never reaches the system bus and is answered with an error. A granted request is forwarded in the same cycle and answered without error.

Top module: `dbg_auth_gate`

## Requirements
- R1: Until the first boot load after reset, no debug request is granted and each one is answered with an error.
- R2: On a boot load the setting is taken from the configuration word when the lifecycle input is 0 (normal), and from the fuse bits when it is 1 (secure).
- R3: A loaded setting of 00 opens the port with the filter in full mode, so every debug address is granted from the cycle after the load.
- R4: A loaded setting of 01 (authenticated) clears both port enable and port disable and sets the filter to admit nothing, so every request is refused.
- R5: A loaded setting with bit 1 set (10 or 11) sets port disable, and no later privileged write can grant any request before the next boot load.
- R6: A privileged write from any master other than the security master ID is rejected: `pw_err` is 1 in the cycle after it and no register changes.
- R7: With the port enabled and the filter in window mode, only the mailbox word and the aligned RAM window are granted. All other addresses are refused.
- R8: With the port enabled and the filter in full mode, any address is granted.
- R9: Writing the port control register (select 0) ORs data bit 0 into DISABLE and sets ENABLE to data bit 1 only when the resulting DISABLE is 0. Once DISABLE is 1, a write cannot clear it before the next boot load.
- R10: A boot load after an earlier one ORs the new setting into the held one, so a setting can never become less restrictive.
- R11: A refused request gives `dbg_fwd_valid` 0 in its cycle and `dbg_rsp_err` 1 in the next cycle. A granted request gives `dbg_fwd_valid` 1, with the request address forwarded, and `dbg_rsp_err` 0 in the next cycle.
- R12: A privileged write from the security master takes effect for requests in the cycle after the write. Select 1 writes the filter mode: 00 none, 01 window, 10 full, 11 none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_load | input | 1 | One-cycle pulse that loads the restriction setting |
| boot_lc | input | 1 | Lifecycle state: 0 normal, 1 secure |
| boot_cfg_word | input | 2 | Setting from the configuration word |
| boot_fuse | input | 2 | Setting from the fuse bits |
| dbg_req_valid | input | 1 | Debugger request present |
| dbg_req_addr | input | AW | Debugger request address |
| dbg_grant | output | 1 | Current request is allowed |
| dbg_fwd_valid | output | 1 | Request forwarded to the system bus |
| dbg_fwd_addr | output | AW | Forwarded address, zero when not forwarded |
| dbg_rsp_valid | output | 1 | Response for the previous cycle's request |
| dbg_rsp_err | output | 1 | Response carries an error |
| pw_valid | input | 1 | Privileged register write |
| pw_master | input | MW | Master ID of the writer |
| pw_sel | input | 1 | 0 port control, 1 filter mode |
| pw_data | input | 2 | Write data |
| pw_err | output | 1 | Previous cycle's privileged write was rejected |

## Verification
The assertions watch, on every cycle, the following: no grant before the first load or while a permanently disabling setting is held, the error response that follows each refusal, the rejection of foreign writes with all registers unchanged, the rule that a set DISABLE never coexists with ENABLE and never clears without a load, and the rule that the held setting never relaxes. Only the bench's scenarios can show the staged flow. That flow runs from refused, to mailbox and RAM window only, to full access. They also show the choice between the configuration word and the fuse bits, and the exact window edges, where one address past the RAM window or the mailbox word is refused.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_WINDOW = 2'b01,
        FLT_FULL   = 2'b10,
        FLT_RSVD   = 2'b11
    } flt_mode_e;

    typedef struct packed {
        logic dis;
        logic en;
    } port_ctl_t;

    typedef struct packed {
        port_ctl_t ctl;
        flt_mode_e flt;
    } gate_state_t;

    localparam logic [1:0] RESTR_OPEN = 2'b00;
    localparam logic [1:0] RESTR_AUTH = 2'b01;

    // state installed by a boot load for a given restriction setting
    function automatic gate_state_t boot_state(input logic [1:0] restr);
        gate_state_t s;
        if (restr[1]) begin
            s.ctl = '{dis: 1'b1, en: 1'b0};
            s.flt = FLT_NONE;
        end else if (restr == RESTR_AUTH) begin
            s.ctl = '{dis: 1'b0, en: 1'b0};
            s.flt = FLT_NONE;
        end else begin
            s.ctl = '{dis: 1'b0, en: 1'b1};
            s.flt = FLT_FULL;
        end
        return s;
    endfunction

    // port control write: disable is sticky, enable only lands when disable is clear
    function automatic port_ctl_t ctl_write(input port_ctl_t cur, input logic [1:0] d);
        port_ctl_t n;
        n.dis = cur.dis | d[0];
        n.en  = n.dis ? 1'b0 : d[1];
        return n;
    endfunction

endpackage

// File: rtl/dbg_gate_boot.sv
module dbg_gate_boot (
    input  logic       clk,
    input  logic       rst,
    input  logic       boot_load,
    input  logic       boot_lc,
    input  logic [1:0] boot_cfg_word,
    input  logic [1:0] boot_fuse,
    output logic       booted_q,
    output logic [1:0] restr_q,
    output logic [1:0] restr_nxt
);
    logic [1:0] src_sel;

    always_comb begin
        src_sel   = boot_lc ? boot_fuse : boot_cfg_word;
        restr_nxt = booted_q ? (restr_q | src_sel) : src_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            booted_q <= 1'b0;
            restr_q  <= 2'b00;
        end else if (boot_load) begin
            booted_q <= 1'b1;
            restr_q  <= restr_nxt;
        end
    end
endmodule

// File: rtl/dbg_gate_regs.sv
module dbg_gate_regs
    import dbg_gate_pkg::*;
#(
    parameter int              MW         = 4,
    parameter logic [MW-1:0]   SEC_MASTER = 4'd2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boot_load,
    input  logic [1:0]    restr_nxt,
    input  logic          pw_valid,
    input  logic [MW-1:0] pw_master,
    input  logic          pw_sel,
    input  logic [1:0]    pw_data,
    output port_ctl_t     ctl_q,
    output flt_mode_e     flt_q,
    output logic          pw_err
);
    logic        pw_ok;
    gate_state_t boot_s;

    always_comb begin
        pw_ok  = pw_valid && (pw_master == SEC_MASTER);
        boot_s = boot_state(restr_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{dis: 1'b0, en: 1'b0};
            flt_q  <= FLT_NONE;
            pw_err <= 1'b0;
        end else begin
            pw_err <= pw_valid && !pw_ok;
            if (boot_load) begin
                ctl_q <= boot_s.ctl;
                flt_q <= boot_s.flt;
            end else if (pw_ok) begin
                if (pw_sel) flt_q <= flt_mode_e'(pw_data);
                else        ctl_q <= ctl_write(ctl_q, pw_data);
            end
        end
    end
endmodule

// File: rtl/dbg_gate_filter.sv
module dbg_gate_filter
    import dbg_gate_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] MBX_ADDR = 32'h4000_0100,
    parameter logic [AW-1:0] RAM_BASE = 32'h2000_0000,
    parameter int            RAM_LG   = 8
) (
    input  flt_mode_e     mode,
    input  logic [AW-1:0] addr,
    output logic          permit
);
    localparam int WORD_LG = 2;
    logic mbx_hit;
    logic ram_hit;

    // aligned compare: low bits below the region size are ignored
    always_comb begin
        mbx_hit = (addr >> WORD_LG) == (MBX_ADDR >> WORD_LG);
        ram_hit = (addr >> RAM_LG)  == (RAM_BASE >> RAM_LG);
        unique case (mode)
            FLT_FULL:   permit = 1'b1;
            FLT_WINDOW: permit = mbx_hit || ram_hit;
            default:    permit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbg_auth_gate.sv
module dbg_auth_gate
    import dbg_gate_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            MW         = 4,
    parameter logic [MW-1:0] SEC_MASTER = 4'd2,
    parameter logic [AW-1:0] MBX_ADDR   = 32'h4000_0100,
    parameter logic [AW-1:0] RAM_BASE   = 32'h2000_0000,
    parameter int            RAM_LG     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boot_load,
    input  logic          boot_lc,
    input  logic [1:0]    boot_cfg_word,
    input  logic [1:0]    boot_fuse,
    input  logic          dbg_req_valid,
    input  logic [AW-1:0] dbg_req_addr,
    output logic          dbg_grant,
    output logic          dbg_fwd_valid,
    output logic [AW-1:0] dbg_fwd_addr,
    output logic          dbg_rsp_valid,
    output logic          dbg_rsp_err,
    input  logic          pw_valid,
    input  logic [MW-1:0] pw_master,
    input  logic          pw_sel,
    input  logic [1:0]    pw_data,
    output logic          pw_err
);
    logic      booted_q;
    logic [1:0] restr_q;
    logic [1:0] restr_nxt;
    port_ctl_t ctl_q;
    flt_mode_e flt_q;
    logic      permit;
    logic      allow;

    dbg_gate_boot i_boot (
        .clk           (clk),
        .rst           (rst),
        .boot_load     (boot_load),
        .boot_lc       (boot_lc),
        .boot_cfg_word (boot_cfg_word),
        .boot_fuse     (boot_fuse),
        .booted_q      (booted_q),
        .restr_q       (restr_q),
        .restr_nxt     (restr_nxt)
    );

    dbg_gate_regs #(.MW(MW), .SEC_MASTER(SEC_MASTER)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .boot_load (boot_load),
        .restr_nxt (restr_nxt),
        .pw_valid  (pw_valid),
        .pw_master (pw_master),
        .pw_sel    (pw_sel),
        .pw_data   (pw_data),
        .ctl_q     (ctl_q),
        .flt_q     (flt_q),
        .pw_err    (pw_err)
    );

    dbg_gate_filter #(
        .AW(AW), .MBX_ADDR(MBX_ADDR), .RAM_BASE(RAM_BASE), .RAM_LG(RAM_LG)
    ) i_filter (
        .mode   (flt_q),
        .addr   (dbg_req_addr),
        .permit (permit)
    );

    always_comb begin
        allow         = booted_q && ctl_q.en && !ctl_q.dis && permit;
        dbg_grant     = dbg_req_valid && allow;
        dbg_fwd_valid = dbg_grant;
        dbg_fwd_addr  = dbg_grant ? dbg_req_addr : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dbg_rsp_valid <= 1'b0;
            dbg_rsp_err   <= 1'b0;
        end else begin
            dbg_rsp_valid <= dbg_req_valid;
            dbg_rsp_err   <= dbg_req_valid && !allow;
        end
    end
endmodule

// File: rtl/dbg_auth_gate_chk.sv
module dbg_auth_gate_chk #(
    parameter int            MW         = 4,
    parameter logic [MW-1:0] SEC_MASTER = 4'd2
) (
    input logic          clk,
    input logic          rst,
    input logic          boot_load,
    input logic          dbg_req_valid,
    input logic          dbg_grant,
    input logic          dbg_rsp_valid,
    input logic          dbg_rsp_err,
    input logic          pw_valid,
    input logic [MW-1:0] pw_master,
    input logic          pw_err,
    input logic          booted_q,
    input logic [1:0]    restr_q,
    input logic [1:0]    ctl_q,
    input logic [1:0]    flt_q
);
    logic seen_boot;
    always_ff @(posedge clk) begin
        if (rst) seen_boot <= 1'b0;
        else if (boot_load) seen_boot <= 1'b1;
    end

    assert_no_grant_preboot_R1: assert property (@(posedge clk) disable iff (rst)
        !seen_boot |-> !dbg_grant);

    assert_locked_no_grant_R5: assert property (@(posedge clk) disable iff (rst)
        (booted_q && restr_q[1]) |-> !dbg_grant);

    assert_foreign_write_err_R6: assert property (@(posedge clk) disable iff (rst)
        (pw_valid && pw_master != SEC_MASTER) |=> pw_err);

    assert_foreign_write_noeffect_R6: assert property (@(posedge clk) disable iff (rst)
        (pw_valid && pw_master != SEC_MASTER && !boot_load) |=> ($stable(ctl_q) && $stable(flt_q)));

    assert_dis_blocks_en_R9: assert property (@(posedge clk) disable iff (rst)
        ctl_q[1] |-> !ctl_q[0]);

    assert_dis_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[1] && !boot_load) |=> ctl_q[1]);

    assert_restr_monotonic_R10: assert property (@(posedge clk) disable iff (rst)
        booted_q |=> ((restr_q & $past(restr_q)) == $past(restr_q)));

    assert_refuse_err_R11: assert property (@(posedge clk) disable iff (rst)
        (dbg_req_valid && !dbg_grant) |=> (dbg_rsp_valid && dbg_rsp_err));

    assert_grant_ok_R11: assert property (@(posedge clk) disable iff (rst)
        dbg_grant |=> (dbg_rsp_valid && !dbg_rsp_err));
endmodule

bind dbg_auth_gate dbg_auth_gate_chk #(.MW(MW), .SEC_MASTER(SEC_MASTER)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .boot_load     (boot_load),
    .dbg_req_valid (dbg_req_valid),
    .dbg_grant     (dbg_grant),
    .dbg_rsp_valid (dbg_rsp_valid),
    .dbg_rsp_err   (dbg_rsp_err),
    .pw_valid      (pw_valid),
    .pw_master     (pw_master),
    .pw_err        (pw_err),
    .booted_q      (booted_q),
    .restr_q       (restr_q),
    .ctl_q         (ctl_q),
    .flt_q         (flt_q)
);

// File: tb/test_dbg_auth_gate.sv
module test_dbg_auth_gate;
    localparam int AW = 32;
    localparam int MW = 4;
    localparam logic [31:0] MBX = 32'h4000_0100;
    localparam logic [31:0] RAM = 32'h2000_0000;
    localparam logic [31:0] FAR = 32'h1000_0000;

    localparam logic [1:0] K_BOOT = 2'd0;
    localparam logic [1:0] K_PW   = 2'd1;
    localparam logic [1:0] K_REQ  = 2'd2;

    // x/y: boot -> cfg word / fuse ; pw -> sel / data. exp: grant for REQ, pw_err for PW
    typedef struct packed {
        logic [1:0]  kind;
        logic        lc;
        logic [1:0]  x;
        logic [1:0]  y;
        logic [3:0]  m;
        logic [31:0] addr;
        logic        exp;
        logic [7:0]  rq;
    } step_t;

    localparam int NSTEP = 26;
    localparam step_t TBL [NSTEP] = '{
        '{K_BOOT, 1'b0, 2'b01, 2'b00, 4'd0, 32'h0,        1'b0, 8'd2 },  // R2 normal picks cfg=01
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, MBX,          1'b0, 8'd4 },  // R4 blocked
        '{K_PW,   1'b0, 2'b00, 2'b10, 4'd5, 32'h0,        1'b1, 8'd6 },  // R6 foreign ctl write
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, MBX,          1'b0, 8'd6 },  // R6 no effect
        '{K_PW,   1'b0, 2'b00, 2'b10, 4'd2, 32'h0,        1'b0, 8'd12},  // R12 enable port
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, MBX,          1'b0, 8'd7 },  // R7 filter none
        '{K_PW,   1'b0, 2'b01, 2'b01, 4'd2, 32'h0,        1'b0, 8'd12},  // R12 filter window
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, MBX,          1'b1, 8'd7 },  // R7 mailbox
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, MBX + 32'd3,  1'b1, 8'd7 },  // R7 mailbox last byte
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, MBX + 32'd4,  1'b0, 8'd7 },  // R7 past mailbox
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, RAM + 32'h80, 1'b1, 8'd7 },  // R7 ram window
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, RAM + 32'hFF, 1'b1, 8'd7 },  // R7 ram last byte
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, RAM + 32'h100,1'b0, 8'd7 },  // R7 past ram
        '{K_PW,   1'b0, 2'b01, 2'b10, 4'd7, 32'h0,        1'b1, 8'd6 },  // R6 foreign filter write
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, FAR,          1'b0, 8'd6 },  // R6 still window
        '{K_PW,   1'b0, 2'b01, 2'b10, 4'd2, 32'h0,        1'b0, 8'd12},  // R12 filter full
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, FAR,          1'b1, 8'd8 },  // R8 full access
        '{K_PW,   1'b0, 2'b00, 2'b11, 4'd2, 32'h0,        1'b0, 8'd9 },  // R9 dis+en together
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, FAR,          1'b0, 8'd9 },  // R9 refused
        '{K_PW,   1'b0, 2'b00, 2'b10, 4'd2, 32'h0,        1'b0, 8'd9 },  // R9 try clear dis
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, FAR,          1'b0, 8'd9 },  // R9 still refused
        '{K_BOOT, 1'b0, 2'b00, 2'b00, 4'd0, 32'h0,        1'b0, 8'd10},  // R10 reload 00 -> stays 01
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, FAR,          1'b0, 8'd10},  // R10 refused
        '{K_BOOT, 1'b1, 2'b00, 2'b10, 4'd0, 32'h0,        1'b0, 8'd5 },  // R5 secure fuse=10
        '{K_PW,   1'b0, 2'b00, 2'b10, 4'd2, 32'h0,        1'b0, 8'd5 },  // R5 enable write
        '{K_REQ,  1'b0, 2'b00, 2'b00, 4'd0, MBX,          1'b0, 8'd5 }   // R5 refused
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          boot_load, boot_lc;
    logic [1:0]    boot_cfg_word, boot_fuse;
    logic          dbg_req_valid;
    logic [AW-1:0] dbg_req_addr;
    logic          dbg_grant, dbg_fwd_valid, dbg_rsp_valid, dbg_rsp_err;
    logic [AW-1:0] dbg_fwd_addr;
    logic          pw_valid, pw_sel;
    logic [MW-1:0] pw_master;
    logic [1:0]    pw_data;
    logic          pw_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dbg_auth_gate i_dbg_auth_gate (
        .clk(clk), .rst(rst),
        .boot_load(boot_load), .boot_lc(boot_lc),
        .boot_cfg_word(boot_cfg_word), .boot_fuse(boot_fuse),
        .dbg_req_valid(dbg_req_valid), .dbg_req_addr(dbg_req_addr),
        .dbg_grant(dbg_grant), .dbg_fwd_valid(dbg_fwd_valid),
        .dbg_fwd_addr(dbg_fwd_addr), .dbg_rsp_valid(dbg_rsp_valid),
        .dbg_rsp_err(dbg_rsp_err), .pw_valid(pw_valid),
        .pw_master(pw_master), .pw_sel(pw_sel), .pw_data(pw_data),
        .pw_err(pw_err)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic idle();
        boot_load = 0; boot_lc = 0; boot_cfg_word = 0; boot_fuse = 0;
        dbg_req_valid = 0; dbg_req_addr = 0;
        pw_valid = 0; pw_sel = 0; pw_master = 0; pw_data = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic do_boot(input logic lc, input logic [1:0] cfg, input logic [1:0] fuse);
        @(negedge clk);
        boot_load = 1; boot_lc = lc; boot_cfg_word = cfg; boot_fuse = fuse;
        @(negedge clk); idle();
    endtask

    task automatic do_pw(input logic [3:0] m, input logic sel, input logic [1:0] d,
                         input logic exp_err, input string rq);
        @(negedge clk);
        pw_valid = 1; pw_master = m; pw_sel = sel; pw_data = d;
        @(negedge clk); idle();
        check({rq, " pw_err"}, {31'd0, pw_err}, {31'd0, exp_err});
    endtask

    task automatic do_req(input logic [31:0] a, input logic exp_g, input string rq);
        @(negedge clk);
        dbg_req_valid = 1; dbg_req_addr = a;
        #1;
        check({rq, " grant"}, {31'd0, dbg_grant}, {31'd0, exp_g});
        check({rq, " R11 fwd_valid"}, {31'd0, dbg_fwd_valid}, {31'd0, exp_g});
        check({rq, " R11 fwd_addr"}, dbg_fwd_addr, exp_g ? a : 32'd0);
        @(negedge clk); idle();
        check({rq, " R11 rsp_valid"}, {31'd0, dbg_rsp_valid}, 32'd1);
        check({rq, " R11 rsp_err"}, {31'd0, dbg_rsp_err}, {31'd0, !exp_g});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(); rst = 1;
        do_reset();
        // R1 reset state and pre-boot refusal
        check("R1 rsp_valid after reset", {31'd0, dbg_rsp_valid}, 32'd0);
        check("R1 pw_err after reset", {31'd0, pw_err}, 32'd0);
        do_req(FAR, 1'b0, "R1");
        do_pw(4'd2, 1'b0, 2'b10, 1'b0, "R1");
        do_pw(4'd2, 1'b1, 2'b10, 1'b0, "R1");
        do_req(FAR, 1'b0, "R1 writes before boot");

        do_reset();
        for (int i = 0; i < NSTEP; i++) begin
            string tag;
            tag = $sformatf("R%0d step%0d", TBL[i].rq, i);
            case (TBL[i].kind)
                K_BOOT:  do_boot(TBL[i].lc, TBL[i].x, TBL[i].y);
                K_PW:    do_pw(TBL[i].m, TBL[i].x[0], TBL[i].y, TBL[i].exp, tag);
                default: do_req(TBL[i].addr, TBL[i].exp, tag);
            endcase
        end

        // R2 R3: secure picks fuse 00 even with cfg word 01
        do_reset();
        do_boot(1'b1, 2'b01, 2'b00);
        do_req(FAR, 1'b1, "R2 R3 secure fuse open");
        do_req(MBX, 1'b1, "R3 open any address");

        // R3 normal cfg 00, next-cycle effect
        do_reset();
        do_boot(1'b0, 2'b00, 2'b11);
        do_req(32'hFFFF_FFFC, 1'b1, "R3 normal cfg open");

        // R5 setting 11 from cfg word, security master tries full open
        do_reset();
        do_boot(1'b0, 2'b11, 2'b00);
        do_pw(4'd2, 1'b1, 2'b10, 1'b0, "R5");
        do_pw(4'd2, 1'b0, 2'b10, 1'b0, "R5");
        do_req(RAM, 1'b0, "R5 locked");

        // R12 filter code 11 acts as none
        do_reset();
        do_boot(1'b0, 2'b01, 2'b00);
        do_pw(4'd2, 1'b0, 2'b10, 1'b0, "R12");
        do_pw(4'd2, 1'b1, 2'b11, 1'b0, "R12");
        do_req(MBX, 1'b0, "R12 filter code 11");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule